// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block provides message signalling between the two sides of a two-port shared memory. The two topmost words of the memory array act as mailboxes. Port B owns the very last word. Port A owns the word just below it. When one side writes the other side's mailbox, the owner of that mailbox receives an interrupt. The owner acknowledges the interrupt by reading its own mailbox.

The block sits beside the memory array and watches the same control signals the array receives from each port: enable, read/write select, address and the busy result from the contention arbiter. It holds one interrupt flag per port. The mailbox data lives in the ordinary array, so the data value plays no part in this block. A port whose busy input is active has lost arbitration, and its access neither sets nor clears any flag.

Accesses are sampled on the rising clock edge. The interrupt outputs are registered and change on the same edge that samples the access. The mailbox addresses follow the address-width parameter `ADDR_W`.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the clock edge that samples it low, both `a_irq_n` and `b_irq_n` go to 1 (interrupt inactive).
- R2: An access sampled with `b_en_n`=0, `b_wr_n`=0 (0 means write), `b_addr`=2^ADDR_W−2 and `b_busy_n`=1 drives `a_irq_n` to 0 after that edge.
- R3: An access sampled with `a_en_n`=0, `a_wr_n`=0, `a_addr`=2^ADDR_W−1 and `a_busy_n`=1 drives `b_irq_n` to 0 after that edge.
- R4: An access sampled with `a_en_n`=0, `a_wr_n`=1 (1 means read), `a_addr`=2^ADDR_W−2 and `a_busy_n`=1 drives `a_irq_n` to 1. Port B behaves the same way with its own mailbox address 2^ADDR_W−1. R8 overrides this rule.
- R5: A read by one port of the other port's mailbox address leaves the other port's interrupt output unchanged.
- R6: A write to the other port's mailbox does not change that port's interrupt while the writer's busy input is 0 (busy active).
- R7: A read of a port's own mailbox does not change that port's interrupt while the reader's busy input is 0 (busy active).
- R8: If a set (R2 or R3) and a clear (R4) of the same interrupt are sampled on the same edge, the interrupt ends active (0).
- R9: The following accesses do not change any interrupt output:
  - an access with the enable input at 1 (inactive);
  - an access to any address other than the two mailboxes;
  - a write by a port to its own mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; accesses are sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_en_n | input | 1 | Port A access enable, active low |
| a_wr_n | input | 1 | Port A direction: 0 = write, 1 = read |
| a_addr | input | ADDR_W | Port A word address |
| a_busy_n | input | 1 | Port A busy from the arbiter, active low |
| b_en_n | input | 1 | Port B access enable, active low |
| b_wr_n | input | 1 | Port B direction: 0 = write, 1 = read |
| b_addr | input | ADDR_W | Port B word address |
| b_busy_n | input | 1 | Port B busy from the arbiter, active low |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
Directed sequences cover these cases:
- Cross-writes that set each flag, which distinguish the two mailbox addresses.
- Reads of the other port's mailbox, which distinguish an owner's acknowledge from an observer's peek.
- The same accesses with busy active, which show that busy gates both the set and the clear.
- A write and an acknowledge of the same flag on one edge, which exposes the priority between set and clear.

Random traffic is weighted toward the two mailbox words and the word just below them. It mixes the enable, direction and busy inputs freely, so near-miss addresses and disabled accesses are compared against a bench model on every cycle.

// File: rtl/mbx_irq_pkg.sv
// Package mbx_irq_pkg
// Shared definitions for the mailbox interrupt controller.
// Assumes the address width is below 32 bits.
package mbx_irq_pkg;

    // Index of each port in the internal per-port arrays.
    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } mbx_port_e;

    localparam int unsigned NUM_PORTS = 2;

    // Mailbox word owned by a port: A gets 2^aw-2, B gets 2^aw-1.
    function automatic logic [31:0] mbx_box_addr(input int unsigned aw, input int unsigned port);
        logic [31:0] top;
        top = (32'd1 << aw) - 32'd2;
        return top + port;
    endfunction

    // Index of the port on the other side.
    function automatic int unsigned mbx_peer(input int unsigned port);
        return (port == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
// Module mbx_port_decode
// Decodes one port's sampled access into two events:
//   own_rd_hit  - the port reads its own mailbox while it holds arbitration
//   peer_wr_hit - the port writes the peer's mailbox while it holds arbitration
// Assumes active-low enable and busy, and wr_n = 0 meaning write.
module mbx_port_decode #(
    parameter int unsigned          ADDR_W   = 13,
    parameter logic [ADDR_W-1:0]    OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0]    PEER_BOX = '0
) (
    input  logic              en_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output logic              own_rd_hit,
    output logic              peer_wr_hit
);

    logic granted;
    logic is_own;
    logic is_peer;

    // Access counts only when enabled and not blocked by the arbiter.
    always_comb begin
        granted = !en_n && busy_n;
        is_own  = (addr == OWN_BOX);
        is_peer = (addr == PEER_BOX);
    end

    // Classify the granted access by direction and target mailbox.
    always_comb begin
        own_rd_hit  = granted && wr_n && is_own;
        peer_wr_hit = granted && !wr_n && is_peer;
    end

endmodule

// File: rtl/mbx_irq_flag.sv
// Module mbx_irq_flag
// Holds one interrupt flag, presented active low.
// A set beats a clear on the same edge. Reset is synchronous and active low,
// and leaves the output inactive (high).
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    // Update the flag: reset, then set, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else if (set) begin
            irq_n <= 1'b0;
        end else if (clr) begin
            irq_n <= 1'b1;
        end
    end

endmodule

// File: rtl/mbx_irq_ctrl.sv
// Module mbx_irq_ctrl
// Top level of the mailbox interrupt controller. One decoder per port
// classifies that port's access. A port's flag is set by the peer's mailbox
// write and cleared by the port's own mailbox read.
// Assumes every input is synchronous to clk.
module mbx_irq_ctrl
    import mbx_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en_n,
    input  logic              a_wr_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_busy_n,
    input  logic              b_en_n,
    input  logic              b_wr_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_busy_n,
    output logic              a_irq_n,
    output logic              b_irq_n
);

    logic              en_n   [NUM_PORTS];
    logic              wr_n   [NUM_PORTS];
    logic [ADDR_W-1:0] addr   [NUM_PORTS];
    logic              busy_n [NUM_PORTS];
    logic              rd_hit [NUM_PORTS];
    logic              wr_hit [NUM_PORTS];
    logic              irq_n  [NUM_PORTS];

    // Gather the named ports into per-port arrays.
    always_comb begin
        en_n[PORT_A]   = a_en_n;
        wr_n[PORT_A]   = a_wr_n;
        addr[PORT_A]   = a_addr;
        busy_n[PORT_A] = a_busy_n;
        en_n[PORT_B]   = b_en_n;
        wr_n[PORT_B]   = b_wr_n;
        addr[PORT_B]   = b_addr;
        busy_n[PORT_B] = b_busy_n;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int unsigned       PEER     = mbx_peer(p);
        localparam logic [ADDR_W-1:0] OWN_BOX  = ADDR_W'(mbx_box_addr(ADDR_W, p));
        localparam logic [ADDR_W-1:0] PEER_BOX = ADDR_W'(mbx_box_addr(ADDR_W, PEER));

        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN_BOX),
            .PEER_BOX (PEER_BOX)
        ) u_dec (
            .en_n        (en_n[p]),
            .wr_n        (wr_n[p]),
            .addr        (addr[p]),
            .busy_n      (busy_n[p]),
            .own_rd_hit  (rd_hit[p]),
            .peer_wr_hit (wr_hit[p])
        );

        mbx_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (wr_hit[PEER]),
            .clr   (rd_hit[p]),
            .irq_n (irq_n[p])
        );
    end

    // Drive the named outputs from the per-port flags.
    always_comb begin
        a_irq_n = irq_n[PORT_A];
        b_irq_n = irq_n[PORT_B];
    end

endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
// Module mbx_irq_ctrl_chk
// Temporal checks on the ports of mbx_irq_ctrl, attached with bind.
module mbx_irq_ctrl_chk #(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_en_n,
    input logic              a_wr_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_busy_n,
    input logic              b_en_n,
    input logic              b_wr_n,
    input logic [ADDR_W-1:0] b_addr,
    input logic              b_busy_n,
    input logic              a_irq_n,
    input logic              b_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};

    logic set_a, set_b, clr_a, clr_b;

    // Events that the requirements name, derived from the ports.
    always_comb begin
        set_a = !b_en_n && !b_wr_n && (b_addr == BOX_A) && b_busy_n;
        set_b = !a_en_n && !a_wr_n && (a_addr == BOX_B) && a_busy_n;
        clr_a = !a_en_n && a_wr_n && (a_addr == BOX_A) && a_busy_n;
        clr_b = !b_en_n && b_wr_n && (b_addr == BOX_B) && b_busy_n;
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (a_irq_n && b_irq_n));

    p_set_a_r2: assert property (@(posedge clk) disable iff (!rst_n) set_a |=> !a_irq_n);

    p_set_b_r3: assert property (@(posedge clk) disable iff (!rst_n) set_b |=> !b_irq_n);

    p_clr_a_r4: assert property (@(posedge clk) disable iff (!rst_n) (clr_a && !set_a) |=> a_irq_n);

    p_clr_b_r4: assert property (@(posedge clk) disable iff (!rst_n) (clr_b && !set_b) |=> b_irq_n);

    // R5, R6, R7 and R9: nothing else moves a flag.
    p_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n) (!set_a && !clr_a) |=> $stable(a_irq_n));

    p_hold_b_r9: assert property (@(posedge clk) disable iff (!rst_n) (!set_b && !clr_b) |=> $stable(b_irq_n));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n) (set_a && clr_a) |=> !a_irq_n);

endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_en_n   (a_en_n),
    .a_wr_n   (a_wr_n),
    .a_addr   (a_addr),
    .a_busy_n (a_busy_n),
    .b_en_n   (b_en_n),
    .b_wr_n   (b_wr_n),
    .b_addr   (b_addr),
    .b_busy_n (b_busy_n),
    .a_irq_n  (a_irq_n),
    .b_irq_n  (b_irq_n)
);

// File: tb/test_mbx_irq_ctrl.sv
// Bench for mbx_irq_ctrl: directed corner cases, then seeded random traffic,
// each cycle compared against a reference model held in the bench.
module test_mbx_irq_ctrl;

    localparam int unsigned ADDR_W = 13;
    localparam logic [ADDR_W-1:0] BOX_A = ADDR_W'((32'd1 << ADDR_W) - 2);
    localparam logic [ADDR_W-1:0] BOX_B = ADDR_W'((32'd1 << ADDR_W) - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en_n = 1'b1, a_wr_n = 1'b1, a_busy_n = 1'b1;
    logic b_en_n = 1'b1, b_wr_n = 1'b1, b_busy_n = 1'b1;
    logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
    logic a_irq_n, b_irq_n;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic exp_a_n = 1'b1, exp_b_n = 1'b1;

    always #4 clk = ~clk;

    mbx_irq_ctrl #(.ADDR_W(ADDR_W)) i_mbx_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .a_en_n(a_en_n), .a_wr_n(a_wr_n), .a_addr(a_addr), .a_busy_n(a_busy_n),
        .b_en_n(b_en_n), .b_wr_n(b_wr_n), .b_addr(b_addr), .b_busy_n(b_busy_n),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    // Reference rule: a granted write to the peer's mailbox sets the peer's flag.
    function automatic bit ref_set(bit en_n, bit wr_n, logic [ADDR_W-1:0] ad, bit busy_n,
                                   logic [ADDR_W-1:0] box);
        return !en_n && !wr_n && busy_n && (ad == box);
    endfunction

    // Reference rule: a granted read of the own mailbox clears the own flag.
    function automatic bit ref_clr(bit en_n, bit wr_n, logic [ADDR_W-1:0] ad, bit busy_n,
                                   logic [ADDR_W-1:0] box);
        return !en_n && wr_n && busy_n && (ad == box);
    endfunction

    // Next active-low flag value; a set wins over a clear.
    function automatic logic ref_next(logic cur_n, bit set, bit clr);
        if (set) return 1'b0;
        if (clr) return 1'b1;
        return cur_n;
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive one cycle of access on both ports, update the model, and compare.
    task automatic cycle(bit ae, bit aw, logic [ADDR_W-1:0] aa, bit ab,
                         bit be, bit bw, logic [ADDR_W-1:0] ba, bit bb,
                         string req_a, string req_b);
        bit sa, ca, sb, cb;
        @(negedge clk);
        a_en_n = ae; a_wr_n = aw; a_addr = aa; a_busy_n = ab;
        b_en_n = be; b_wr_n = bw; b_addr = ba; b_busy_n = bb;
        sa = ref_set(be, bw, ba, bb, BOX_A);
        ca = ref_clr(ae, aw, aa, ab, BOX_A);
        sb = ref_set(ae, aw, aa, ab, BOX_B);
        cb = ref_clr(be, bw, ba, bb, BOX_B);
        @(posedge clk);
        #2;
        exp_a_n = ref_next(exp_a_n, sa, ca);
        exp_b_n = ref_next(exp_b_n, sb, cb);
        if (req_a != "") check(req_a, a_irq_n, exp_a_n, "a_irq_n");
        if (req_b != "") check(req_b, b_irq_n, exp_b_n, "b_irq_n");
    endtask

    task automatic idle_cycle(string req);
        cycle(1, 1, '0, 1, 1, 1, '0, 1, req, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a_en_n = 1'b1; b_en_n = 1'b1;
        @(posedge clk);
        #2;
        exp_a_n = 1'b1; exp_b_n = 1'b1;
        check("R1", a_irq_n, 1'b1, "a_irq_n in reset");
        check("R1", b_irq_n, 1'b1, "b_irq_n in reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [ADDR_W-1:0] pick_addr();
        int unsigned r;
        r = $urandom_range(0, 7);
        if (r < 3) return BOX_A;
        if (r < 6) return BOX_B;
        if (r == 6) return BOX_A - 1;
        return ADDR_W'($urandom);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        do_reset();

        // R2: B writes A's mailbox.
        cycle(1, 1, '0, 1, 0, 0, BOX_A, 1, "R2", "R2");
        // R3: A writes B's mailbox.
        cycle(0, 0, BOX_B, 1, 1, 1, '0, 1, "R3", "R3");
        // R5: A peeks at B's mailbox, B peeks at A's mailbox.
        cycle(0, 1, BOX_B, 1, 0, 1, BOX_A, 1, "R5", "R5");
        check("R5", b_irq_n, 1'b0, "b_irq_n after peer peek");
        // R7: A reads its own mailbox while busy is active.
        cycle(0, 1, BOX_A, 0, 1, 1, '0, 1, "R7", "R7");
        check("R7", a_irq_n, 1'b0, "a_irq_n blocked clear");
        // R4: A and B read their own mailboxes.
        cycle(0, 1, BOX_A, 1, 0, 1, BOX_B, 1, "R4", "R4");
        check("R4", a_irq_n, 1'b1, "a_irq_n after ack");
        // R6: writes to the peer's mailbox while busy is active.
        cycle(0, 0, BOX_B, 0, 0, 0, BOX_A, 0, "R6", "R6");
        check("R6", a_irq_n, 1'b1, "a_irq_n blocked set");
        // R9: writes to the own mailbox, a near-miss address, disabled access.
        cycle(0, 0, BOX_A, 1, 0, 0, BOX_B, 1, "R9", "R9");
        cycle(0, 0, BOX_B - 2, 1, 0, 0, BOX_A - 1, 1, "R9", "R9");
        cycle(1, 0, BOX_B, 1, 1, 0, BOX_A, 1, "R9", "R9");
        // R8: set A, then a set and a clear of A on the same edge.
        cycle(1, 1, '0, 1, 0, 0, BOX_A, 1, "R2", "");
        cycle(0, 1, BOX_A, 1, 0, 0, BOX_A, 1, "R8", "");
        check("R8", a_irq_n, 1'b0, "a_irq_n set beats clear");
        // R1: reset while both flags are set.
        cycle(0, 0, BOX_B, 1, 0, 0, BOX_A, 1, "R3", "R2");
        do_reset();

        // Random traffic compared against the model.
        for (int i = 0; i < 3000; i++) begin
            bit ae, aw, ab, be, bw, bb;
            logic [ADDR_W-1:0] aa, ba;
            string ra, rb;
            ae = ($urandom_range(0, 3) == 0);
            aw = $urandom_range(0, 1);
            ab = ($urandom_range(0, 3) != 0);
            be = ($urandom_range(0, 3) == 0);
            bw = $urandom_range(0, 1);
            bb = ($urandom_range(0, 3) != 0);
            aa = pick_addr();
            ba = pick_addr();
            if (ref_set(be, bw, ba, bb, BOX_A)) ra = "R2";
            else if (ref_clr(ae, aw, aa, ab, BOX_A)) ra = "R4";
            else ra = "R9";
            if (ref_set(ae, aw, aa, ab, BOX_B)) rb = "R3";
            else if (ref_clr(be, bw, ba, bb, BOX_B)) rb = "R4";
            else rb = "R9";
            cycle(ae, aw, aa, ab, be, bw, ba, bb, ra, rb);
        end
        idle_cycle("R9");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule